// File: doc/BRIEF.md
# Loader Password Gate

This block sits beside the command decoder of a serial bootloader and decides whether memory-reading and memory-writing commands may run in the current session. The host sends a password frame. The frame parser hands the 32 payload bytes to this block as a stream: a start strobe, one valid strobe per byte, and a done strobe once the frame has ended. The block checks the stream against the 32 bytes of the interrupt vector region, which it receives as a flat input image. It keeps a sticky mismatch flag while the bytes arrive and makes its decision only at the done strobe.

A 16-bit security word selects one of three policies.
- Keep: a wrong password has no further effect.
- Erase: a wrong password raises a one-cycle request to wipe the whole memory.
- Off: the loader is disabled outright, and every password frame is ignored.

Once the password matches, the unlocked flag stays set until a new loader entry pulses the session-reset input. The frame acknowledge pulse comes out for every frame the block accepts, so it says nothing about whether the password was right.

Top module: `pw_guard`

## Requirements
- R1: Byte k of the stream (k = 0 first) is compared with `vec_image[8k+7:8k]`, which is the byte at vector address base+k. A frame whose bytes match in that order sets `unlocked`. The same bytes in any other order do not set it.
- R2: Once `unlocked` is 1, it stays 1 through any later frame, including a frame with a wrong password, until `session_rst` is asserted.
- R3: `frame_ack` is high for exactly one cycle, in the cycle after an accepted done strobe. It is produced whether or not the password matched.
- R4: With security word 0x0000, a wrong password never raises `erase_req`.
- R5: With any security word other than 0x0000 and 0xAA55, a wrong password raises `erase_req` for exactly one cycle, in the same cycle as `frame_ack`.
- R6: With security word 0xAA55, `loader_off` is 1 from the cycle after the word is applied. While `loader_off` is 1, start, byte and done strobes are ignored: there is no `frame_ack`, no unlock and no erase request.
- R7: A done strobe after fewer or more than 32 bytes counts as a wrong password.
- R8: After `rst_n` is released, `unlocked`, `erase_req`, `frame_ack` and `loader_off` are all 0.
- R9: After an erase, when the vector image reads as all 0xFF, a password of 32 bytes of 0xFF unlocks the session.
- R10: `session_rst` clears `unlocked` in the next cycle and abandons any frame in progress. A done strobe that follows with no new start produces no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| session_rst | input | 1 | New loader entry: relocks the session |
| pw_start | input | 1 | Start of a password frame |
| pw_valid | input | 1 | A password byte is present on pw_byte |
| pw_byte | input | 8 | Password byte |
| pw_done | input | 1 | End of the password frame |
| vec_image | input | 256 | Vector region image; byte k sits at bits 8k+7:8k |
| sec_word | input | 16 | Security policy word |
| unlocked | output | 1 | Protected commands are allowed |
| erase_req | output | 1 | One-cycle mass-erase request |
| frame_ack | output | 1 | One-cycle acknowledge for a password frame |
| loader_off | output | 1 | The loader is disabled by the security word |

## Verification
The in-RTL assertions check on every cycle that:
- the erase request is one cycle long, comes only with an acknowledge, and comes only under the erase policy;
- the unlocked flag holds until a session reset, and clears after one;
- no acknowledge follows a cycle in which the loader was off;
- the byte counter stays within its bound.

Only the bench scenarios can show that the comparison follows address order, that a short or long frame fails, that an all-0xFF image accepts an all-0xFF password, and that an abandoned frame stays silent. To cover these, a behavioural model is compared with all four outputs on every clock.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

   typedef enum logic [1:0] {
      POL_KEEP  = 2'd0,
      POL_ERASE = 2'd1,
      POL_OFF   = 2'd2
   } pwg_pol_e;

   function automatic pwg_pol_e pwg_decode(input logic [15:0] word,
                                           input logic [15:0] keep_code,
                                           input logic [15:0] off_code);
      if (word == off_code)       return POL_OFF;
      else if (word == keep_code) return POL_KEEP;
      else                        return POL_ERASE;
   endfunction

endpackage

// File: rtl/pwg_policy.sv
module pwg_policy
   import pwg_pkg::*;
#(
   parameter int SEC_W = 16,
   parameter logic [SEC_W-1:0] KEEP_CODE = 16'h0000,
   parameter logic [SEC_W-1:0] OFF_CODE  = 16'hAA55
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEC_W-1:0] sec_word,
   output pwg_pol_e         pol,
   output logic             off
);

   generate
      if (SEC_W != 16) begin : g_bad_w
         $error("pwg_policy: SEC_W must be 16");
      end
      if (KEEP_CODE == OFF_CODE) begin : g_bad_codes
         $error("pwg_policy: keep and off codes must differ");
      end
   endgenerate

   pwg_pol_e pol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pol_q <= POL_KEEP;
      else        pol_q <= pwg_decode(sec_word, KEEP_CODE, OFF_CODE);
   end

   assign pol = pol_q;
   assign off = (pol_q == POL_OFF);

   AST_POL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      pol_q != 2'd3); // R6

endmodule

// File: rtl/pwg_compare.sv
module pwg_compare #(
   parameter int PW_BYTES = 32,
   parameter int BYTE_W   = 8,
   localparam int IMG_W   = PW_BYTES * BYTE_W,
   localparam int CNT_W   = $clog2(PW_BYTES + 2),
   localparam int IDX_W   = $clog2(PW_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              take,
   input  logic [BYTE_W-1:0] data,
   input  logic [IMG_W-1:0]  image,
   output logic              match
);

   generate
      if (PW_BYTES < 2) begin : g_bad_len
         $error("pwg_compare: PW_BYTES must be at least 2");
      end
      if (BYTE_W < 1) begin : g_bad_w
         $error("pwg_compare: BYTE_W must be positive");
      end
   endgenerate

   localparam logic [CNT_W-1:0] FULL = CNT_W'(PW_BYTES);
   localparam logic [CNT_W-1:0] OVER = CNT_W'(PW_BYTES + 1);

   logic [BYTE_W-1:0] slot [PW_BYTES];

   genvar g;
   generate
      for (g = 0; g < PW_BYTES; g++) begin : g_slot
         assign slot[g] = image[g*BYTE_W +: BYTE_W];
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             miss;
   logic [IDX_W-1:0] idx;
   logic             in_range;

   assign idx      = cnt[IDX_W-1:0];
   assign in_range = (cnt < FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         miss <= 1'b0;
      end else if (clear) begin
         cnt  <= '0;
         miss <= 1'b0;
      end else if (take) begin
         if (in_range) begin
            cnt <= cnt + 1'b1;
            if (data != slot[idx]) miss <= 1'b1;
         end else begin
            cnt  <= OVER;
            miss <= 1'b1;
         end
      end
   end

   assign match = !miss && (cnt == FULL);

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= OVER); // R7
   AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      miss && !clear |=> miss); // R1

endmodule

// File: rtl/pwg_lock.sv
module pwg_lock
   import pwg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     session_rst,
   input  logic     start,
   input  logic     done,
   input  logic     off,
   input  logic     match,
   input  pwg_pol_e pol,
   output logic     active,
   output logic     unlocked,
   output logic     erase_req,
   output logic     ack
);

   logic start_ok, done_ok;

   assign start_ok = start && !off;
   assign done_ok  = done && active && !off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         unlocked  <= 1'b0;
         erase_req <= 1'b0;
         ack       <= 1'b0;
      end else begin
         erase_req <= 1'b0;
         ack       <= 1'b0;
         if (session_rst) begin
            unlocked <= 1'b0;
            active   <= 1'b0;
         end else if (start_ok) begin
            active <= 1'b1;
         end else if (done_ok) begin
            active <= 1'b0;
            ack    <= 1'b1;
            if (match)                 unlocked  <= 1'b1;
            else if (pol == POL_ERASE) erase_req <= 1'b1;
         end
      end
   end

   AST_ERASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |=> !erase_req); // R5
   AST_ERASE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> ack); // R3
   AST_ERASE_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> $past(pol) == POL_ERASE); // R4
   AST_UNLOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      unlocked && !session_rst |=> unlocked); // R2
   AST_SESSION_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      session_rst |=> !unlocked && !active); // R10

endmodule

// File: rtl/pw_guard.sv
module pw_guard
   import pwg_pkg::*;
#(
   parameter int PW_BYTES = 32,
   parameter int BYTE_W   = 8,
   parameter int SEC_W    = 16,
   parameter logic [SEC_W-1:0] KEEP_CODE = 16'h0000,
   parameter logic [SEC_W-1:0] OFF_CODE  = 16'hAA55
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       session_rst,
   input  logic                       pw_start,
   input  logic                       pw_valid,
   input  logic [BYTE_W-1:0]          pw_byte,
   input  logic                       pw_done,
   input  logic [PW_BYTES*BYTE_W-1:0] vec_image,
   input  logic [SEC_W-1:0]           sec_word,
   output logic                       unlocked,
   output logic                       erase_req,
   output logic                       frame_ack,
   output logic                       loader_off
);

   pwg_pol_e pol;
   logic     off, active, match;

   pwg_policy #(
      .SEC_W(SEC_W), .KEEP_CODE(KEEP_CODE), .OFF_CODE(OFF_CODE)
   ) policy_i (
      .clk(clk), .rst_n(rst_n), .sec_word(sec_word), .pol(pol), .off(off)
   );

   pwg_compare #(
      .PW_BYTES(PW_BYTES), .BYTE_W(BYTE_W)
   ) compare_i (
      .clk(clk), .rst_n(rst_n),
      .clear(pw_start && !off),
      .take(pw_valid && active && !off),
      .data(pw_byte), .image(vec_image), .match(match)
   );

   pwg_lock lock_i (
      .clk(clk), .rst_n(rst_n), .session_rst(session_rst),
      .start(pw_start), .done(pw_done), .off(off), .match(match), .pol(pol),
      .active(active), .unlocked(unlocked), .erase_req(erase_req), .ack(frame_ack)
   );

   assign loader_off = off;

   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ack |-> !$past(loader_off)); // R6

endmodule

// File: tb/pw_guard_tb_top.sv
`timescale 1ns/1ps
module pw_guard_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         session_rst = 1'b0, pw_start = 1'b0, pw_valid = 1'b0, pw_done = 1'b0;
   logic [7:0]   pw_byte = '0;
   logic [255:0] vec_image;
   logic [15:0]  sec_word = 16'h1234;
   logic         unlocked, erase_req, frame_ack, loader_off;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   pw_guard dut_i (
      .clk(clk), .rst_n(rst_n), .session_rst(session_rst), .pw_start(pw_start),
      .pw_valid(pw_valid), .pw_byte(pw_byte), .pw_done(pw_done),
      .vec_image(vec_image), .sec_word(sec_word), .unlocked(unlocked),
      .erase_req(erase_req), .frame_ack(frame_ack), .loader_off(loader_off)
   );

   // behavioural reference model
   int   m_pol = 0;            // 0 keep, 1 erase, 2 off
   bit   m_active = 0, m_unl = 0, m_erase = 0, m_ack = 0;
   byte unsigned m_q[$];

   function automatic bit pw_ok();
      if (m_q.size() != 32) return 0;
      for (int i = 0; i < 32; i++)
         if (m_q[i] != vec_image[i*8 +: 8]) return 0;
      return 1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pol = 0; m_active = 0; m_unl = 0; m_erase = 0; m_ack = 0; m_q.delete();
      end else begin
         m_erase = 0; m_ack = 0;
         if (session_rst) begin
            m_unl = 0; m_active = 0; m_q.delete();
         end else if (m_pol != 2) begin
            if (pw_start) begin
               m_active = 1; m_q.delete();
            end else if (pw_done && m_active) begin
               m_active = 0; m_ack = 1;
               if (pw_ok()) m_unl = 1;
               else if (m_pol == 1) m_erase = 1;
            end else if (pw_valid && m_active) begin
               m_q.push_back(pw_byte);
            end
         end
         m_pol = (sec_word == 16'hAA55) ? 2 : (sec_word == 16'h0000) ? 0 : 1;
      end
   end

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n && !finished) begin
      chk("R2", "model unlocked", unlocked, m_unl);
      chk("R5", "model erase_req", erase_req, m_erase);
      chk("R3", "model frame_ack", frame_ack, m_ack);
      chk("R6", "model loader_off", loader_off, m_pol == 2);
   end

   function automatic logic [255:0] pattern();
      logic [255:0] v;
      for (int i = 0; i < 32; i++) v[i*8 +: 8] = 8'(i * 7 + 3);
      return v;
   endfunction

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // mode 0 in order, 1 reversed, 2 all 0xFF; len bytes; returns after the done edge
   task automatic send(input int mode, input int len);
      pw_start = 1; @(negedge clk); pw_start = 0;
      for (int i = 0; i < len; i++) begin
         pw_valid = 1;
         pw_byte = (mode == 2) ? 8'hFF :
                   (mode == 1) ? vec_image[(31 - (i % 32))*8 +: 8] : vec_image[(i % 32)*8 +: 8];
         @(negedge clk);
      end
      pw_valid = 0;
      pw_done = 1; @(negedge clk); pw_done = 0;
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      vec_image = pattern();
      idle(2);
      chk("R8", "reset unlocked", unlocked, 0);
      chk("R8", "reset erase_req", erase_req, 0);
      chk("R8", "reset frame_ack", frame_ack, 0);
      chk("R8", "reset loader_off", loader_off, 0);
      rst_n = 1; idle(3);

      send(1, 32);   // reversed order under erase policy
      chk("R1", "reversed unlocked", unlocked, 0);
      chk("R3", "ack after wrong", frame_ack, 1);
      chk("R5", "erase pulse", erase_req, 1);
      idle(1);
      chk("R5", "erase one cycle", erase_req, 0);
      chk("R3", "ack one cycle", frame_ack, 0);

      vec_image = '1; idle(1);
      send(2, 32);
      chk("R9", "erased image unlocks", unlocked, 1);
      chk("R3", "ack after right", frame_ack, 1);
      chk("R5", "no erase on match", erase_req, 0);

      send(1, 32);
      chk("R2", "stays unlocked", unlocked, 1);
      idle(4);
      chk("R2", "still unlocked", unlocked, 1);

      session_rst = 1; idle(1); session_rst = 0;
      chk("R10", "session relock", unlocked, 0);

      sec_word = 16'h0000; vec_image = pattern(); idle(2);
      send(0, 31);
      chk("R7", "short frame", unlocked, 0);
      chk("R4", "no erase keep", erase_req, 0);
      send(0, 33);
      chk("R7", "long frame", unlocked, 0);
      chk("R4", "no erase keep long", erase_req, 0);
      send(0, 32);
      chk("R1", "in order unlocks", unlocked, 1);

      session_rst = 1; idle(1); session_rst = 0;
      pw_start = 1; idle(1); pw_start = 0;
      pw_valid = 1; pw_byte = vec_image[7:0]; idle(1); pw_valid = 0;
      session_rst = 1; idle(1); session_rst = 0;
      pw_done = 1; idle(1); pw_done = 0;
      chk("R10", "abandoned frame no ack", frame_ack, 0);

      sec_word = 16'hAA55; idle(1);
      chk("R6", "loader_off set", loader_off, 1);
      send(0, 32);
      chk("R6", "off no ack", frame_ack, 0);
      chk("R6", "off no unlock", unlocked, 0);
      sec_word = 16'h5A5A; idle(2);
      chk("R6", "loader_off clear", loader_off, 0);
      send(1, 32);
      chk("R5", "erase on other code", erase_req, 1);
      idle(3);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule